// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block sits between free-running internal clocks and the clock output buffers. It lets the system park two groups of clocks for low-power operation without creating runt pulses. The processor group holds the processor copies and the memory copies together. The bus group holds only the bus copies. Each group has its own asynchronous, active-low hold request. A low level parks the group, and a high level lets it run.

Each request is first brought into the domain of the clock it controls by a chain of rising-edge flops. It then passes through one falling-edge enable register. The enable can therefore change only while its clock is low. A parked output rests at logic low, and the first pulse after a release is a complete high phase. The number of rising-edge stages is set per group, and that number is the latency in whole cycles.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_ni` is low, every gated output is held low.
- R2: Each hold request is synchronized in its own clock domain through `CPU_SYNC_STAGES` (default 1) or `BUS_SYNC_STAGES` (default 2) rising-edge flops, followed by one falling-edge enable register.
- R3: Suppose a low on `cpu_hold_ni` is first sampled at rising edge k of `clk_cpu_i`. Then the pulses beginning at edges k to k+CPU_SYNC_STAGES-1 are still delivered in full, and no pulse starts from edge k+CPU_SYNC_STAGES on. With the default this means at most one further pulse.
- R4: Suppose a high on `cpu_hold_ni` is first sampled at rising edge k. Then the first delivered processor pulse begins at edge k+CPU_SYNC_STAGES and has a full high width.
- R5: The bus group parks and restarts by the rules of R3 and R4, using `clk_bus_i` and `BUS_SYNC_STAGES`. With the default this is two cycles, which stays under four.
- R6: `cpu_hold_ni` parks and restarts all processor and memory copies on the same edges, with identical waveforms. The bus copies are not affected.
- R7: `bus_hold_ni` affects only the bus copies. The processor and memory copies keep running.
- R8: A parked output sits at logic low, including during what would be the high phase of its source clock.
- R9: No gated output ever shows a high pulse shorter than half its source period, wherever a request edge falls. Enables change only while their clock is low.
- R10: A hold pulse that begins and ends between two rising edges of its domain clock is never sampled and has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low reset, asynchronous assert; release away from clock edges |
| clk_cpu_i | input | 1 | Free-running internal processor clock |
| clk_bus_i | input | 1 | Free-running internal bus clock |
| cpu_hold_ni | input | 1 | Asynchronous request, low parks processor and memory copies |
| bus_hold_ni | input | 1 | Asynchronous request, low parks bus copies |
| cpu_clk_o | output | N_CPU | Gated processor clock copies |
| mem_clk_o | output | N_MEM | Gated memory clock copies (same group as processor) |
| bus_clk_o | output | N_BUS | Gated bus clock copies |

## Verification
A stuck or mis-timed enable shows up at the ports within one window of a few cycles after the request changes. The count of delivered rising edges departs from the synchronizer depth, or a parked output reads high at mid-phase. An enable register that updates on the wrong edge produces a shortened high pulse on the first or last cycle around a request edge. The bench measures every high width on one copy of each group, so that fault is caught on the very pulse it corrupts. A split between the processor and memory gates appears as unequal copies sampled in the same high phase.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // State of one gate: a single enable sampled in the low phase of its clock.
    typedef struct packed {
        logic en;
    } gate_st_t;

    localparam gate_st_t GATE_ST_RESET = '{en: 1'b0};

    // A synchronizer resets to "parked" so outputs stay low until a run request
    // has been seen in the destination domain.
    localparam logic SYNC_RESET_LEVEL = 1'b0;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync
    import clkstop_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    localparam int AW = $clog2(STAGES + 1) + 1;

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= {STAGES{SYNC_RESET_LEVEL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

    // Edges seen since reset, saturating; gates the latency check.
    logic [AW-1:0] age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (age_q != AW'(STAGES)) begin
            age_d = age_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            age_q <= '0;
        end else begin
            age_q <= age_d;
        end
    end

    AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == AW'(STAGES)) |-> (sync_o == $past(async_i, STAGES)))
        else $error("synchronizer latency differs from STAGES"); // R2

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int COPIES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    output logic              en_o,
    output logic [COPIES-1:0] clk_o
);

    gate_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = run_i;
    end

    // Falling-edge register: the enable moves only while the clock is low,
    // so a pulse is either passed whole or not at all.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= GATE_ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        assign clk_o[g] = clk_i & st_q.en;
    end

    always @(en_o) begin
        if (rst_ni) begin
            AST_EN_IN_LOW_PHASE: assert (!clk_i)
                else $error("enable moved while clock high"); // R9
        end
    end

    AST_EN_FOLLOWS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o == run_i)
        else $error("enable lags synchronized request"); // R3

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
    import clkstop_pkg::*;
#(
    parameter int N_CPU           = 4,
    parameter int N_MEM           = 6,
    parameter int N_BUS           = 6,
    parameter int CPU_SYNC_STAGES = 1,
    parameter int BUS_SYNC_STAGES = 2
) (
    input  logic             rst_ni,
    input  logic             clk_cpu_i,
    input  logic             clk_bus_i,
    input  logic             cpu_hold_ni,
    input  logic             bus_hold_ni,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_MEM-1:0] mem_clk_o,
    output logic [N_BUS-1:0] bus_clk_o
);

    logic cpu_run, bus_run;
    logic cpu_en, mem_en, bus_en;

    clkstop_sync #(.STAGES(CPU_SYNC_STAGES)) i_cpu_sync (
        .clk_i   (clk_cpu_i),
        .rst_ni  (rst_ni),
        .async_i (cpu_hold_ni),
        .sync_o  (cpu_run)
    );

    clkstop_sync #(.STAGES(BUS_SYNC_STAGES)) i_bus_sync (
        .clk_i   (clk_bus_i),
        .rst_ni  (rst_ni),
        .async_i (bus_hold_ni),
        .sync_o  (bus_run)
    );

    clkstop_gate #(.COPIES(N_CPU)) i_cpu_gate (
        .clk_i  (clk_cpu_i),
        .rst_ni (rst_ni),
        .run_i  (cpu_run),
        .en_o   (cpu_en),
        .clk_o  (cpu_clk_o)
    );

    clkstop_gate #(.COPIES(N_MEM)) i_mem_gate (
        .clk_i  (clk_cpu_i),
        .rst_ni (rst_ni),
        .run_i  (cpu_run),
        .en_o   (mem_en),
        .clk_o  (mem_clk_o)
    );

    clkstop_gate #(.COPIES(N_BUS)) i_bus_gate (
        .clk_i  (clk_bus_i),
        .rst_ni (rst_ni),
        .run_i  (bus_run),
        .en_o   (bus_en),
        .clk_o  (bus_clk_o)
    );

    AST_CPU_MEM_LOCK: assert property (@(posedge clk_cpu_i) disable iff (!rst_ni)
        cpu_en == mem_en)
        else $error("processor and memory enables split"); // R6

    AST_BUS_ALONE: assert property (@(posedge clk_bus_i) disable iff (!rst_ni)
        bus_en == bus_run)
        else $error("bus enable lags its own request"); // R7

endmodule

// File: tb/test_clk_stop_gate.sv
`timescale 1ns/1ps
module test_clk_stop_gate;

    localparam int CLK_PERIOD = 10;   // processor clock period
    localparam int BUS_PERIOD = 24;   // bus clock period, unrelated phase
    localparam int N_CPU = 4, N_MEM = 6, N_BUS = 6;
    localparam int CPU_LAT = 1, BUS_LAT = 2, WIN = 6;

    logic clk_cpu = 1'b0, clk_bus = 1'b0;
    logic rst_n = 1'b1;
    logic cpu_hold_n = 1'b1, bus_hold_n = 1'b1;
    logic [N_CPU-1:0] cpu_clk;
    logic [N_MEM-1:0] mem_clk;
    logic [N_BUS-1:0] bus_clk;

    int checks = 0, errors = 0;
    int cpu_g = 0, mem_g = 0, bus_g = 0, cpu_raw = 0, bus_raw = 0;
    int runt_cpu = 0, runt_mem = 0, runt_bus = 0;
    realtime t_cpu = 0, t_mem = 0, t_bus = 0;

    always #(CLK_PERIOD/2) clk_cpu = ~clk_cpu;
    always #(BUS_PERIOD/2) clk_bus = ~clk_bus;

    clk_stop_gate #(.N_CPU(N_CPU), .N_MEM(N_MEM), .N_BUS(N_BUS)) i_clk_stop_gate (
        .rst_ni      (rst_n),
        .clk_cpu_i   (clk_cpu),
        .clk_bus_i   (clk_bus),
        .cpu_hold_ni (cpu_hold_n),
        .bus_hold_ni (bus_hold_n),
        .cpu_clk_o   (cpu_clk),
        .mem_clk_o   (mem_clk),
        .bus_clk_o   (bus_clk)
    );

    always @(posedge clk_cpu)    cpu_raw++;
    always @(posedge clk_bus)    bus_raw++;
    always @(posedge cpu_clk[0]) begin cpu_g++; t_cpu = $realtime; end
    always @(posedge mem_clk[0]) begin mem_g++; t_mem = $realtime; end
    always @(posedge bus_clk[0]) begin bus_g++; t_bus = $realtime; end
    always @(negedge cpu_clk[0]) if ($realtime - t_cpu < CLK_PERIOD/2.0 - 0.001) runt_cpu++;
    always @(negedge mem_clk[0]) if ($realtime - t_mem < CLK_PERIOD/2.0 - 0.001) runt_mem++;
    always @(negedge bus_clk[0]) if ($realtime - t_bus < BUS_PERIOD/2.0 - 0.001) runt_bus++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_counts();
        cpu_g = 0; mem_g = 0; bus_g = 0; cpu_raw = 0; bus_raw = 0;
    endtask

    task automatic cpu_window();
        clear_counts();
        repeat (WIN) @(posedge clk_cpu);
        #1;
    endtask

    task automatic bus_window();
        clear_counts();
        repeat (WIN) @(posedge clk_bus);
        #1;
    endtask

    task automatic t_reset();
        #1 rst_n = 1'b0;
        #55; // processor clock high
        chk(cpu_clk == '0, "R1 cpu in reset", int'(cpu_clk), 0);
        chk(mem_clk == '0, "R1 mem in reset", int'(mem_clk), 0);
        #6;  // bus clock high as well
        chk(bus_clk == '0, "R1 bus in reset", int'(bus_clk), 0);
        #40 rst_n = 1'b1; // t = 102, away from edges
        repeat (10) @(posedge clk_bus);
    endtask

    task automatic t_free_run();
        cpu_window();
        chk(cpu_g == cpu_raw, "R6 cpu running", cpu_g, cpu_raw);
        chk(mem_g == cpu_raw, "R6 mem running", mem_g, cpu_raw);
        chk(bus_g == bus_raw, "R7 bus running", bus_g, bus_raw);
        chk(cpu_clk == {N_CPU{1'b1}} && mem_clk == {N_MEM{1'b1}}, "R6 copies equal",
            int'(cpu_clk), (1 << N_CPU) - 1);
    endtask

    task automatic t_cpu_stop_start();
        @(posedge clk_cpu); #7 cpu_hold_n = 1'b0;
        cpu_window();
        chk(cpu_g == CPU_LAT, "R3 R2 cpu pulses after hold", cpu_g, CPU_LAT);
        chk(mem_g == CPU_LAT, "R6 mem pulses after hold", mem_g, CPU_LAT);
        chk(bus_g == bus_raw, "R6 bus undisturbed", bus_g, bus_raw);
        chk(cpu_clk == '0 && mem_clk == '0, "R8 cpu parked low", int'(cpu_clk), 0);
        @(posedge clk_cpu); #7 cpu_hold_n = 1'b1;
        cpu_window();
        chk(cpu_g == WIN - CPU_LAT, "R4 cpu pulses after release", cpu_g, WIN - CPU_LAT);
        chk(mem_g == WIN - CPU_LAT, "R6 mem pulses after release", mem_g, WIN - CPU_LAT);
    endtask

    task automatic t_bus_stop_start();
        @(posedge clk_bus); #18 bus_hold_n = 1'b0;
        bus_window();
        chk(bus_g == BUS_LAT, "R5 R2 bus pulses after hold", bus_g, BUS_LAT);
        chk(cpu_g == cpu_raw, "R7 cpu undisturbed", cpu_g, cpu_raw);
        chk(mem_g == cpu_raw, "R7 mem undisturbed", mem_g, cpu_raw);
        chk(bus_clk == '0, "R8 bus parked low", int'(bus_clk), 0);
        @(posedge clk_bus); #18 bus_hold_n = 1'b1;
        bus_window();
        chk(bus_g == WIN - BUS_LAT, "R5 bus pulses after release", bus_g, WIN - BUS_LAT);
    endtask

    task automatic t_both_parked();
        cpu_hold_n = 1'b0; bus_hold_n = 1'b0;
        repeat (4) @(posedge clk_bus);
        bus_window();
        chk(cpu_g == 0 && mem_g == 0, "R8 cpu group silent", cpu_g + mem_g, 0);
        chk(bus_g == 0, "R8 bus group silent", bus_g, 0);
        cpu_hold_n = 1'b1; bus_hold_n = 1'b1;
        repeat (4) @(posedge clk_bus);
    endtask

    task automatic t_short_pulse();
        clear_counts();
        @(posedge clk_cpu); #6 cpu_hold_n = 1'b0; #2 cpu_hold_n = 1'b1;
        repeat (WIN) @(posedge clk_cpu); #1;
        chk(cpu_g == cpu_raw, "R10 cpu ignores short hold", cpu_g, cpu_raw);
        clear_counts();
        @(posedge clk_bus); #14 bus_hold_n = 1'b0; #6 bus_hold_n = 1'b1;
        repeat (WIN) @(posedge clk_bus); #1;
        chk(bus_g == bus_raw, "R10 bus ignores short hold", bus_g, bus_raw);
    endtask

    task automatic t_sweep();
        runt_cpu = 0; runt_mem = 0; runt_bus = 0;
        fork
            for (int off = 0; off < 10; off++) begin
                @(posedge clk_cpu); #(off) cpu_hold_n = ~cpu_hold_n;
                repeat (2) @(posedge clk_cpu);
            end
            for (int off = 0; off < 12; off++) begin
                @(posedge clk_bus); #(2*off+1) bus_hold_n = ~bus_hold_n;
                repeat (3) @(posedge clk_bus);
            end
        join
        cpu_hold_n = 1'b1; bus_hold_n = 1'b1;
        repeat (6) @(posedge clk_bus);
        chk(runt_cpu == 0, "R9 cpu high widths", runt_cpu, 0);
        chk(runt_mem == 0, "R9 mem high widths", runt_mem, 0);
        chk(runt_bus == 0, "R9 bus high widths", runt_bus, 0);
        cpu_window();
        chk(cpu_g == cpu_raw && bus_g == bus_raw, "R4 R5 running after sweep",
            cpu_g + bus_g, cpu_raw + bus_raw);
    endtask

    initial begin
        #(200000 * CLK_PERIOD);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_free_run();
        t_cpu_stop_start();
        t_bus_stop_start();
        t_both_parked();
        t_short_pulse();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule